// File: doc/BRIEF.md
# Clock-Forwarded 4:1 Serializer

This block turns a stream of parallel words into a single bit-serial stream that runs at four times the word rate. The fast serial clock comes in from outside the block. The block divides it by the word width and sends the result out as a parallel clock, which paces the upstream word source.

The source sends its own clock back with each word. The block captures the word into an input register on that returned clock. On a fixed serial phase, the shift register takes the captured word and sends it out most significant bit first.

The returned clock edge may drift within a skew window around the divided clock. The load phase is placed so that the captured word is stable at the moment of transfer anywhere in that window. No handshake or retiming is needed between the two clock domains.

Top module: `ser4_serializer`

## Requirements
- R1: The input register captures `par_data` on every rising edge of `par_clk_in`. The most recently captured word is the one that is serialized.
- R2: `par_clk_out` toggles at one quarter of the `ser_clk` rate. It follows a 2-bit phase that counts 0,1,2,3 on every `ser_clk` edge. It is high for phases 0 and 1, low for phases 2 and 3, and rises on the edge that enters phase 0.
- R3: The shift register loads the captured word on the `ser_clk` edge that enters phase 3, three serial cycles after `par_clk_out` rises.
- R4: Bit 3 of each loaded word appears on `ser_out` first and bit 0 last. Between loads the register shifts one place toward the output on each `ser_clk` edge and fills with zeros.
- R5: Serial output stays correct for any `par_clk_in` rising edge from about 0.11 word periods before to about 0.51 word periods after the `par_clk_out` rising edge, including jitter inside that range.
- R6: The latency is fixed. Bit 3 of a word captured in the window around a `par_clk_out` rise is on `ser_out` from the third to the fourth `ser_clk` edge after that rise. Its other bits follow on the next three edges.
- R7: The reset is synchronous to `ser_clk` and active high. While it is asserted, the phase is 0, `par_clk_out` is high and `ser_out` is low. After release, `ser_out` stays low until the first load, which happens on the third `ser_clk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Fast serial bit clock |
| ser_rst | input | 1 | Synchronous active-high reset in the serial domain |
| par_clk_in | input | 1 | Parallel clock returned by the word source |
| par_data | input | WORD_W | Parallel word, sampled on the rising edge of `par_clk_in` |
| par_clk_out | output | 1 | Serial clock divided by WORD_W, sent to the word source |
| ser_out | output | 1 | Serial data, most significant bit first |

## Verification
A new word can arrive in the input register close to the serial edge that moves the previous word into the shift register. Both ends of the skew window are therefore used deliberately. An early offset places the capture just after one load edge, and a late offset places it shortly before the next. A random-jitter run then sweeps the whole range. Every serial cycle is compared with a behavioural stream model, and each word reassembled from four output bits is compared with a queue of sent words. Either a torn transfer or a word taken one period early or late shows up as a wrong bit or a wrong word.

// File: rtl/ser4_pkg.sv
package ser4_pkg;

   // Phase counter width for a given division ratio (at least one bit).
   function automatic int unsigned phase_bits(input int unsigned ratio);
      return (ratio <= 2) ? 1 : $clog2(ratio);
   endfunction

   // Phase entered on the edge that moves the captured word into the shifter.
   function automatic int unsigned load_phase(input int unsigned ratio);
      return ratio - 1;
   endfunction

endpackage

// File: rtl/ser4_divider.sv
module ser4_divider #(
   parameter int RATIO = 4,
   parameter int PH_W  = 2
) (
   input  logic            clk,
   input  logic            rst,
   output logic [PH_W-1:0] phase_o,
   output logic            load_o,
   output logic            pclk_o
);
   localparam logic [PH_W-1:0] LAST     = PH_W'(RATIO - 1);
   localparam logic [PH_W-1:0] HALF     = PH_W'(RATIO / 2);
   localparam logic [PH_W-1:0] PRE_LOAD = PH_W'(ser4_pkg::load_phase(RATIO) - 1);

   logic [PH_W-1:0] ph_q, ph_n;
   logic            pclk_q;

   always_comb begin
      ph_n = (ph_q == LAST) ? '0 : ph_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q   <= '0;
         pclk_q <= 1'b1;
      end else begin
         ph_q   <= ph_n;
         pclk_q <= (ph_n < HALF);
      end
   end

   assign phase_o = ph_q;
   assign pclk_o  = pclk_q;
   assign load_o  = (ph_q == PRE_LOAD);
endmodule

// File: rtl/ser4_capture.sv
module ser4_capture #(
   parameter int W = 4
) (
   input  logic         pclk_in,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge pclk_in) begin
      q <= d;
   end
endmodule

// File: rtl/ser4_shifter.sv
module ser4_shifter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic         sout,
   output logic         sout_next
);
   logic [W-1:0] q, nxt;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_fill
         assign nxt[i] = load ? d[i] : 1'b0;
      end else begin : g_pass
         assign nxt[i] = load ? d[i] : q[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
   end

   assign sout      = q[W-1];
   assign sout_next = q[W-2];
endmodule

// File: rtl/ser4_serializer.sv
module ser4_serializer #(
   parameter int WORD_W = 4
) (
   input  logic              ser_clk,
   input  logic              ser_rst,
   input  logic              par_clk_in,
   input  logic [WORD_W-1:0] par_data,
   output logic              par_clk_out,
   output logic              ser_out
);
   localparam int PH_W = ser4_pkg::phase_bits(WORD_W);

   if (WORD_W < 2 || (WORD_W % 2) != 0) begin : g_bad_width
      $error("ser4_serializer: WORD_W must be even and at least 2");
   end

   logic [PH_W-1:0]   div_phase;
   logic              load_now;
   logic [WORD_W-1:0] cap_q;
   logic              shift_next;

   ser4_divider #(.RATIO(WORD_W), .PH_W(PH_W)) u_div (
      .clk     (ser_clk),
      .rst     (ser_rst),
      .phase_o (div_phase),
      .load_o  (load_now),
      .pclk_o  (par_clk_out)
   );

   ser4_capture #(.W(WORD_W)) u_cap (
      .pclk_in (par_clk_in),
      .d       (par_data),
      .q       (cap_q)
   );

   ser4_shifter #(.W(WORD_W)) u_shf (
      .clk       (ser_clk),
      .rst       (ser_rst),
      .load      (load_now),
      .d         (cap_q),
      .sout      (ser_out),
      .sout_next (shift_next)
   );
endmodule

// File: rtl/ser4_serializer_chk.sv
module ser4_serializer_chk #(
   parameter int WORD_W = 4,
   parameter int PH_W   = 2
) (
   input logic            ser_clk,
   input logic            ser_rst,
   input logic            par_clk_out,
   input logic            ser_out,
   input logic [PH_W-1:0] phase,
   input logic            cap_msb,
   input logic            shift_next
);
   localparam logic [PH_W-1:0] PRE_LOAD = PH_W'(WORD_W - 2);
   localparam logic [PH_W-1:0] HALF     = PH_W'(WORD_W / 2);

   p_rise_at_zero_r2: assert property (@(posedge ser_clk) disable iff (ser_rst)
      $rose(par_clk_out) |-> (phase == '0));

   p_fall_at_half_r2: assert property (@(posedge ser_clk) disable iff (ser_rst)
      $fell(par_clk_out) |-> (phase == HALF));

   p_load_word_r3: assert property (@(posedge ser_clk) disable iff (ser_rst)
      (phase == PRE_LOAD) |=> (ser_out == $past(cap_msb)));

   p_shift_order_r4: assert property (@(posedge ser_clk) disable iff (ser_rst)
      (phase != PRE_LOAD) |=> (ser_out == $past(shift_next)));

   p_reset_quiet_r7: assert property (@(posedge ser_clk)
      ser_rst |=> (!ser_out && par_clk_out));
endmodule

bind ser4_serializer ser4_serializer_chk #(.WORD_W(WORD_W), .PH_W(PH_W)) u_chk (
   .ser_clk     (ser_clk),
   .ser_rst     (ser_rst),
   .par_clk_out (par_clk_out),
   .ser_out     (ser_out),
   .phase       (div_phase),
   .cap_msb     (cap_q[WORD_W-1]),
   .shift_next  (shift_next)
);

// File: tb/ser4_serializer_test.sv
module ser4_serializer_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int WPER = 80;   // word period in ns (4 serial cycles of 20 ns)

   logic       ser_clk = 1'b0;
   logic       ser_rst = 1'b1;
   logic       par_clk_in = 1'b0;
   logic [3:0] par_data = 4'h0;
   logic       par_clk_out, ser_out;

   int vectors = 0;
   int fails   = 0;

   always #10 ser_clk = ~ser_clk;

   ser4_serializer #(.WORD_W(4)) uut (
      .ser_clk     (ser_clk),
      .ser_rst     (ser_rst),
      .par_clk_in  (par_clk_in),
      .par_data    (par_data),
      .par_clk_out (par_clk_out),
      .ser_out     (ser_out)
   );

   // ---------------- behavioural reference model ----------------
   logic       rst_at_edge = 1'b1;
   int         n = 0;
   logic [3:0] m_sreg = 4'h0;
   logic [3:0] last_word = 4'h0;
   logic [3:0] sent_q[$];
   int         col_cnt = 0;
   logic [3:0] col_w, col_exp;
   int         cur_off = 0;

   always @(posedge ser_clk) rst_at_edge <= ser_rst;

   always @(negedge ser_clk) begin
      if (rst_at_edge) begin
         n = 0;
         m_sreg = 4'h0;
         col_cnt = 0;
         vectors++;
         if (ser_out !== 1'b0 || par_clk_out !== 1'b1) begin
            fails++;
            $display("FAIL R7 in reset: ser_out=%b par_clk_out=%b expected 0 and 1", ser_out, par_clk_out);
         end
      end else begin
         automatic int  idx  = n;
         automatic logic epc = (((idx + 1) % 4) < 2);
         automatic bit   ld  = ((idx % 4) == 2);
         n++;
         if (ld) m_sreg = last_word;
         else    m_sreg = {m_sreg[2:0], 1'b0};
         vectors++;
         if (par_clk_out !== epc) begin
            fails++;
            $display("FAIL R2 edge %0d: par_clk_out=%b expected %b", idx, par_clk_out, epc);
         end
         vectors++;
         if (ser_out !== m_sreg[3]) begin
            fails++;
            if (idx < 2)
               $display("FAIL R7 edge %0d before first load: ser_out=%b expected %b", idx, ser_out, m_sreg[3]);
            else if (ld)
               $display("FAIL R3 load edge %0d: ser_out=%b expected %b", idx, ser_out, m_sreg[3]);
            else
               $display("FAIL R4 shift edge %0d: ser_out=%b expected %b", idx, ser_out, m_sreg[3]);
         end
         // word reassembly against the sent-word queue (fixed latency)
         if (col_cnt > 0 && col_cnt < 4) begin
            col_w = {col_w[2:0], ser_out};
            col_cnt++;
            if (col_cnt == 4) begin
               vectors++;
               if (col_w !== col_exp) begin
                  fails++;
                  $display("FAIL R6 (R1 capture, R5 offset %0d): word=%h expected %h", cur_off, col_w, col_exp);
               end
               col_cnt = 0;
            end
         end
         if (ld && sent_q.size() > 0) begin
            col_exp = sent_q.pop_front();
            col_w   = {3'b000, ser_out};
            col_cnt = 1;
         end
      end
   end

   // ---------------- stimulus ----------------
   function automatic logic [3:0] pick_word(input int k);
      case (k)
         1: return 4'hA;
         2: return 4'h5;
         3: return 4'hF;
         4: return 4'h0;
         5: return 4'h8;
         6: return 4'h1;
         default: return 4'($urandom_range(15));
      endcase
   endfunction

   // base offset in ns relative to the par_clk_out rise; jit > 0 adds random offsets over the whole window
   task automatic burst(input int nw, input int base, input bit jit);
      realtime t0, tgt;
      @(posedge par_clk_out);
      t0 = $realtime;
      par_data = pick_word(1);
      for (int k = 1; k <= nw; k++) begin
         automatic int off = jit ? (int'($urandom_range(48)) - 8) : base;
         cur_off = off;
         tgt = t0 + real'(WPER * k + off);
         #(tgt - $realtime);
         par_clk_in = 1'b1;
         last_word = par_data;
         sent_q.push_back(par_data);
         #15;
         par_clk_in = 1'b0;
         par_data = pick_word(k + 1);
      end
      repeat (24) @(negedge ser_clk);
   endtask

   initial begin
      // preload the input register while in reset (R7 state checked meanwhile)
      #3 par_clk_in = 1'b1;
      #15 par_clk_in = 1'b0;
      repeat (5) @(negedge ser_clk);
      ser_rst = 1'b0;
      burst(20, -8, 1'b0);   // R5 early edge of the window
      burst(20,  1, 1'b0);
      burst(20, 20, 1'b0);
      burst(20, 40, 1'b0);   // R5 late edge of the window
      burst(60,  0, 1'b1);   // R5 jitter across the window
      // mid-stream reset (R7)
      @(negedge ser_clk);
      ser_rst = 1'b1;
      repeat (3) @(negedge ser_clk);
      ser_rst = 1'b0;
      burst(40,  0, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule